// File: doc/BRIEF.md
# Precomputation-Gated Magnitude Comparator

This block compares two unsigned operands, `op_a` and `op_b`, and reports whether `op_a` is strictly greater than `op_b`, with the answer held in a register. To cut switching in the comparison logic, the operand registers are split in two. The high bank holds the top `HI_BITS` bits of each operand. It loads on every accepted pair. The low bank holds the remaining bits. A predictor looks only at the high slices while the pair is still on the inputs. If those slices differ, the result is already decided. The low bank is then not loaded, so the low-order comparator sees no new data and does not toggle.

The predictor outcome is registered next to the high bank. In the following cycle the output register takes 1 if the "greater" prediction was registered and 0 if the "less" prediction was registered. Only when neither fired does it take the result of the low-slice comparator. A wrapping debug counter counts the accepted pairs whose low bank was gated.

Data enters as a stream qualified by `in_valid`. The block has no ready signal: it accepts one pair on every cycle in which `in_valid` is high and never applies back-pressure. Each result appears with `out_valid` exactly two clock edges after its pair was sampled. The consumer must take it in that cycle, because the next valid result replaces it.

Top module: `precomp_gt_cmp`

## Requirements
- R1: A synchronous active-high `rst` clears `out_gt`, `out_valid`, `gate_count`, both operand banks and the registered prediction, whatever `in_valid` carries during reset.
- R2: For a pair sampled with `in_valid` high at clock edge k, `out_valid` is high after edge k+1 and `out_gt` equals 1 if `op_a > op_b` (unsigned) and 0 otherwise.
- R3: When the top `HI_BITS` bits of `op_a` exceed those of `op_b`, the result is 1, and when they are below, the result is 0, taken from the registered prediction and not from the low comparator.
- R4: When the high slices are equal, the low `WIDTH-HI_BITS` bits decide the result, and fully equal operands give 0.
- R5: A pair whose high slices differ is accepted without loading the low operand bank, which keeps its previous contents. `gate_count` rises by one after that edge.
- R6: On a cycle with `in_valid` low nothing is loaded. `out_valid` is low one edge later, `out_gt` keeps its last value and `gate_count` is unchanged.
- R7: `gate_count` is `CNT_W` bits wide and wraps from its maximum value to 0.
- R8: Pairs presented on consecutive cycles each produce one result on consecutive cycles, in order, with no lost or duplicated result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Pair on `op_a`/`op_b` is valid this cycle |
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| out_valid | output | 1 | `out_gt` holds a fresh result |
| out_gt | output | 1 | 1 when `op_a > op_b` for the matching pair |
| gate_count | output | CNT_W | Wrapping count of pairs whose low bank was gated |

## Verification
The assertions take for granted that `in_valid`, `op_a` and `op_b` are known and steady around each rising edge. They also assume the consumer needs no back-pressure, since no property models a stalled output. The bench changes inputs only at falling edges and keeps them defined throughout. Its stimulus mixes pairs with differing high slices, equal high slices, fully equal operands and idle gaps. This way the gated path, the low comparator path and the hold behaviour each occur while reset is low. The counter is narrowed in the bench so that it wraps within the run.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

  // Outcome of the high-slice predictor.
  typedef struct packed {
    logic hi_gt;   // result known to be 1
    logic hi_lt;   // result known to be 0
  } pgc_pred_t;

  function automatic logic pgc_decided(input pgc_pred_t p);
    return p.hi_gt | p.hi_lt;
  endfunction

endpackage

// File: rtl/pgc_predictor.sv
module pgc_predictor
  import pgc_pkg::*;
#(
  parameter int HI_BITS = 1
) (
  input  logic [HI_BITS-1:0] a_hi,
  input  logic [HI_BITS-1:0] b_hi,
  output pgc_pred_t          pred
);

  generate
    if (HI_BITS == 1) begin : g_single
      // One bit per operand: a pair of two-input gates suffices.
      always_comb begin
        pred.hi_gt = a_hi[0] & ~b_hi[0];
        pred.hi_lt = ~a_hi[0] & b_hi[0];
      end
    end else begin : g_multi
      always_comb begin
        pred.hi_gt = (a_hi > b_hi);
        pred.hi_lt = (a_hi < b_hi);
      end
    end
  endgenerate

endmodule

// File: rtl/pgc_operand_regs.sv
module pgc_operand_regs
  import pgc_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int HI_BITS = 1,
  localparam int LO_W   = WIDTH - HI_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  input  pgc_pred_t          pred_in,
  output logic               s1_valid,
  output pgc_pred_t          s1_pred,
  output logic [LO_W-1:0]    lo_a_q,
  output logic [LO_W-1:0]    lo_b_q,
  output logic               lo_gated
);

  logic lo_load;

  always_comb begin
    lo_gated = in_valid & pgc_decided(pred_in);
    lo_load  = in_valid & ~pgc_decided(pred_in);
  end

  // High bank: prediction travels with the accepted pair.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_pred  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) s1_pred <= pred_in;
    end
  end

  // Low bank: loaded only when the high slices could not decide.
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_a_q <= '0;
      lo_b_q <= '0;
    end else if (lo_load) begin
      lo_a_q <= op_a[LO_W-1:0];
      lo_b_q <= op_b[LO_W-1:0];
    end
  end

  // R5: a decided pair leaves the low bank untouched.
  p_lo_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (pred_in.hi_gt || pred_in.hi_lt)) |=> ($stable(lo_a_q) && $stable(lo_b_q)));

  // R6: idle cycles load nothing.
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(lo_a_q) && $stable(lo_b_q) && $stable(s1_pred) && !s1_valid));

  // R3: the registered prediction is never contradictory.
  p_pred_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(s1_pred.hi_gt && s1_pred.hi_lt));

endmodule

// File: rtl/pgc_decide.sv
module pgc_decide
  import pgc_pkg::*;
#(
  parameter int LO_W = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            s1_valid,
  input  pgc_pred_t       s1_pred,
  input  logic [LO_W-1:0] lo_a_q,
  input  logic [LO_W-1:0] lo_b_q,
  output logic            out_valid,
  output logic            out_gt
);

  // MSB-first ripple magnitude chain over the low slice.
  logic [LO_W:0] gt_chain;
  logic [LO_W:0] eq_chain;
  logic          lo_gt;

  assign gt_chain[LO_W] = 1'b0;
  assign eq_chain[LO_W] = 1'b1;

  generate
    for (genvar i = LO_W - 1; i >= 0; i--) begin : g_bit
      assign gt_chain[i] = gt_chain[i+1] | (eq_chain[i+1] & lo_a_q[i] & ~lo_b_q[i]);
      assign eq_chain[i] = eq_chain[i+1] & ~(lo_a_q[i] ^ lo_b_q[i]);
    end
  endgenerate

  assign lo_gt = gt_chain[0];

  logic next_gt;
  always_comb begin
    if (s1_pred.hi_gt)      next_gt = 1'b1;
    else if (s1_pred.hi_lt) next_gt = 1'b0;
    else                    next_gt = lo_gt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_gt    <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_gt <= next_gt;
    end
  end

  // R3: a registered "greater" prediction yields 1, "less" yields 0.
  p_pred_gt_r3: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_pred.hi_gt) |=> (out_valid && out_gt));
  p_pred_lt_r3: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_pred.hi_lt) |=> (out_valid && !out_gt));

  // R4: undecided pairs follow the low operands; equal low slices give 0.
  p_lo_equal_r4: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_pred.hi_gt && !s1_pred.hi_lt && lo_a_q == lo_b_q) |=> !out_gt);

  // R6: result held while no new pair arrives.
  p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> (!out_valid && $stable(out_gt)));

endmodule

// File: rtl/pgc_gate_counter.sv
module pgc_gate_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (bump) count <= count + CNT_W'(1);
  end

  // R5: counter moves only on a gated pair.
  p_cnt_still_r5: assert property (@(posedge clk) disable iff (rst)
    !bump |=> $stable(count));

  // R7: the maximum value rolls over to zero.
  p_cnt_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (bump && (&count)) |=> (count == '0));

endmodule

// File: rtl/precomp_gt_cmp.sv
module precomp_gt_cmp
  import pgc_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int HI_BITS = 1,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             out_valid,
  output logic             out_gt,
  output logic [CNT_W-1:0] gate_count
);

  localparam int LO_W = WIDTH - HI_BITS;

  initial begin
    if (HI_BITS < 1 || HI_BITS >= WIDTH)
      $error("HI_BITS must lie in 1..WIDTH-1");
  end

  pgc_pred_t       pred_now;
  pgc_pred_t       s1_pred;
  logic            s1_valid;
  logic [LO_W-1:0] lo_a_q;
  logic [LO_W-1:0] lo_b_q;
  logic            lo_gated;

  pgc_predictor #(.HI_BITS(HI_BITS)) u_pred (
    .a_hi (op_a[WIDTH-1 -: HI_BITS]),
    .b_hi (op_b[WIDTH-1 -: HI_BITS]),
    .pred (pred_now)
  );

  pgc_operand_regs #(.WIDTH(WIDTH), .HI_BITS(HI_BITS)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .op_a     (op_a),
    .op_b     (op_b),
    .pred_in  (pred_now),
    .s1_valid (s1_valid),
    .s1_pred  (s1_pred),
    .lo_a_q   (lo_a_q),
    .lo_b_q   (lo_b_q),
    .lo_gated (lo_gated)
  );

  pgc_decide #(.LO_W(LO_W)) u_decide (
    .clk       (clk),
    .rst       (rst),
    .s1_valid  (s1_valid),
    .s1_pred   (s1_pred),
    .lo_a_q    (lo_a_q),
    .lo_b_q    (lo_b_q),
    .out_valid (out_valid),
    .out_gt    (out_gt)
  );

  pgc_gate_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .bump  (lo_gated),
    .count (gate_count)
  );

  // R2: each accepted pair yields exactly one result two edges later.
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);

  // R1: reset clears the visible state.
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_gt && gate_count == '0));

endmodule

// File: tb/test_precomp_gt_cmp.sv
module test_precomp_gt_cmp;

  localparam int WIDTH   = 12;
  localparam int HI_BITS = 1;
  localparam int CNT_W   = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [WIDTH-1:0] op_a = '0;
  logic [WIDTH-1:0] op_b = '0;
  logic             out_valid;
  logic             out_gt;
  logic [CNT_W-1:0] gate_count;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  bit exp_q[$];
  bit last_gt = 1'b0;
  int exp_cnt = 0;
  int results_seen = 0;

  always #4 clk = ~clk;

  precomp_gt_cmp #(.WIDTH(WIDTH), .HI_BITS(HI_BITS), .CNT_W(CNT_W)) i_precomp_gt_cmp (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .out_gt(out_gt), .gate_count(gate_count)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: one pair per call, pushes the expected result.
  task automatic drive(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    op_a = a;
    op_b = b;
    exp_q.push_back(a > b);
    if (a[WIDTH-1 -: HI_BITS] != b[WIDTH-1 -: HI_BITS]) exp_cnt = (exp_cnt + 1) % (1 << CNT_W);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = $urandom;
      op_b = $urandom;
    end
  endtask

  // Monitor: R2, R3, R4, R8 on valid results; R6 while idle.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check("R8 unexpected result", 1, 0);
        end else begin
          bit e;
          e = exp_q.pop_front();
          check("R2 out_gt", int'(out_gt), int'(e));
          results_seen++;
        end
        last_gt = out_gt;
      end else begin
        check("R6 out_gt held", int'(out_gt), int'(last_gt));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset with a decided pair on the inputs.
    in_valid = 1'b1;
    op_a = 12'hFFF;
    op_b = 12'h000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 out_gt", int'(out_gt), 0);
    check("R1 gate_count", int'(gate_count), 0);

    // R3: high slice decides.
    drive(12'h800, 12'h7FF);   // 1
    drive(12'h7FF, 12'h800);   // 0
    // R4: equal high slices, low bits decide; equal gives 0.
    drive(12'h123, 12'h122);   // 1
    drive(12'h122, 12'h123);   // 0
    drive(12'h955, 12'h955);   // 0
    drive(12'hA00, 12'hA00);   // 0
    // R5: gated pair followed by undecided pair must still use fresh low bits.
    drive(12'h801, 12'h0FF);   // gated, 1
    drive(12'h001, 12'h002);   // 0
    idle(3);
    check("R5 gate_count", int'(gate_count), exp_cnt);
    check("R8 all results seen", results_seen, 8);

    // R6: idle gap keeps count and output.
    idle(4);
    check("R6 gate_count stable", int'(gate_count), exp_cnt);
    check("R6 out_valid low", int'(out_valid), 0);

    // R8: back-to-back random stream, with R7 wrap exercised (>16 gated).
    for (int i = 0; i < 200; i++) drive(WIDTH'($urandom), WIDTH'($urandom));
    idle(3);
    check("R7 gate_count wrapped", int'(gate_count), exp_cnt);
    check("R8 all results seen", results_seen, 208);
    check("R8 queue empty", exp_q.size(), 0);

    // R7: controlled wrap from a known count.
    for (int i = 0; i < 16; i++) drive(12'h800, 12'h000);
    idle(3);
    check("R7 gate_count after 16 gated", int'(gate_count), exp_cnt);

    // Mixed stream with gaps.
    for (int i = 0; i < 100; i++) begin
      drive(WIDTH'($urandom), WIDTH'($urandom));
      if (i % 7 == 0) idle(1);
    end
    idle(3);
    check("R2 mixed stream count", results_seen, 324);
    check("R5 gate_count final", int'(gate_count), exp_cnt);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule